// File: doc/BRIEF.md
# Shared Register Read-Port Arbiter with Data Broadcast

This block lets several functional-unit requesters share one read port of a register file. Every cycle a fixed-priority picker selects at most one eligible requester. The granted requester's register number drives the port address, and the port read-enable rises in the same cycle. The register file returns its data one cycle later. In that cycle the block raises a go-read strobe to the winner and steers the port data onto that requester's broadcast lane. All other lanes carry zero.

The grant is also stored as a one-cycle-delayed pick. The delayed pick serves three purposes: it drives the go-read strobe, it gates the data steering, and it stops the same requester from being picked again in the next cycle. A single hazard input blocks every requester at once. Each requester takes its register number straight from its input on its issue cycle. After that cycle it uses a copy held from issue.

Top module: `regport_arbiter`

## Requirements
- R1: A requester is eligible only when its request, active and port-usage bits are all 1. If it is not eligible, it never causes a read-enable.
- R2: Among eligible requesters, the lowest index wins, with index 0 highest. At most one requester is granted in any cycle.
- R3: While `hazard_i` is 1, no requester is granted and `port_ren_o` is 0.
- R4: `port_ren_o` is 1 exactly when some requester is granted. `port_addr_o` equals the winner's register number when there is a grant, and 0 when there is none.
- R5: A grant to requester k in one cycle makes `go_rd_o[k]` 1 for exactly the next cycle. No other strobe is 1 in that cycle.
- R6: A requester whose go-read strobe is 1 is not eligible in that cycle, so a constant request is granted at most every other cycle.
- R7: Lane k of `bcast_data_o` (bits k*DATA_W upward) equals `port_rdata_i` while `go_rd_o[k]` is 1, and is 0 otherwise.
- R8: When `issue_i[k]` is 1, requester k uses its lane of `rnum_i` (bits k*RNUM_W upward) directly. When `issue_i[k]` is 0, it uses the value its lane held in the last cycle `issue_i[k]` was 1.
- R9: Reset clears every delayed pick and every held register number. After reset, the strobes are 0 and an unissued requester presents register number 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_REQ | Per-requester read request |
| active_i | input | NUM_REQ | Per-requester unit active/selected flag |
| use_i | input | NUM_REQ | Per-requester flag that the current operation uses this port |
| issue_i | input | NUM_REQ | Per-requester issue-cycle marker |
| rnum_i | input | NUM_REQ*RNUM_W | Register numbers, lane k at bits k*RNUM_W |
| hazard_i | input | 1 | Blocks all requesters on this port |
| port_rdata_i | input | DATA_W | Read data from the register file, one cycle after the address |
| port_addr_o | output | RNUM_W | Port register address |
| port_ren_o | output | 1 | Port read-enable |
| go_rd_o | output | NUM_REQ | Per-requester go-read strobe |
| bcast_data_o | output | NUM_REQ*DATA_W | Per-requester data lanes, lane k at bits k*DATA_W |

## Verification
The properties assume that the register file returns data exactly one cycle after `port_ren_o`. They also assume that the requester inputs are stable across each clock edge. They make no assumption about how requests are spaced or how `hazard_i` behaves, so any mix of these is legal. The stimulus changes inputs only on the falling clock edge. It drives a new `port_rdata_i` value for each grant, so each broadcast lane can be told apart. The stimulus includes constant requests, hazard pulses, issue-then-hold sequences and a reset in the middle of a run, all within those assumptions.

// File: rtl/regport_pkg.sv
package regport_pkg;
  localparam int unsigned PICK_MAX = 32;

  // Index of the lowest set bit among the first n bits; returns n if none.
  function automatic int unsigned first_hit(input logic [PICK_MAX-1:0] v,
                                            input int unsigned n);
    int unsigned idx;
    idx = n;
    for (int unsigned i = 0; i < PICK_MAX; i++) begin
      if (i < n && v[i] && idx == n) idx = i;
    end
    return idx;
  endfunction
endpackage

// File: rtl/prio_pick.sv
module prio_pick import regport_pkg::*; #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] cand_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  logic [PICK_MAX-1:0] cand_ext;
  int unsigned         win;

  always_comb begin
    cand_ext = '0;
    cand_ext[N-1:0] = cand_i;
    win = first_hit(cand_ext, N);
    any_o = (win != N);
    for (int unsigned k = 0; k < N; k++) gnt_o[k] = any_o && (win == k);
  end
endmodule

// File: rtl/rnum_hold.sv
module rnum_hold #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         issue_i,
  input  logic [W-1:0] rnum_i,
  output logic [W-1:0] rnum_o
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= '0;
    else if (issue_i) held_q <= rnum_i;
  end

  assign rnum_o = issue_i ? rnum_i : held_q;
endmodule

// File: rtl/bcast_steer.sv
module bcast_steer #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 32
) (
  input  logic [N-1:0]   sel_i,
  input  logic [W-1:0]   data_i,
  output logic [N*W-1:0] lanes_o
);
  for (genvar k = 0; k < N; k++) begin : g_lane
    assign lanes_o[k*W +: W] = sel_i[k] ? data_i : '0;
  end
endmodule

// File: rtl/regport_arbiter.sv
module regport_arbiter import regport_pkg::*; #(
  parameter int unsigned NUM_REQ = 4,
  parameter int unsigned RNUM_W  = 5,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REQ-1:0]        req_i,
  input  logic [NUM_REQ-1:0]        active_i,
  input  logic [NUM_REQ-1:0]        use_i,
  input  logic [NUM_REQ-1:0]        issue_i,
  input  logic [NUM_REQ*RNUM_W-1:0] rnum_i,
  input  logic                      hazard_i,
  input  logic [DATA_W-1:0]         port_rdata_i,
  output logic [RNUM_W-1:0]         port_addr_o,
  output logic                      port_ren_o,
  output logic [NUM_REQ-1:0]        go_rd_o,
  output logic [NUM_REQ*DATA_W-1:0] bcast_data_o
);
  localparam int unsigned RN_TOTAL = NUM_REQ * RNUM_W;

  initial begin
    if (NUM_REQ > PICK_MAX || NUM_REQ == 0)
      $error("regport_arbiter: NUM_REQ out of range");
  end

  // named internal events (observed by the checker)
  logic [NUM_REQ-1:0]  elig_w;
  logic [NUM_REQ-1:0]  grant_w;
  logic                any_w;
  logic [NUM_REQ-1:0]  dpick_q;
  logic [RN_TOTAL-1:0] rnum_eff_w;

  for (genvar k = 0; k < NUM_REQ; k++) begin : g_hold
    rnum_hold #(.W(RNUM_W)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .issue_i(issue_i[k]),
      .rnum_i (rnum_i[k*RNUM_W +: RNUM_W]),
      .rnum_o (rnum_eff_w[k*RNUM_W +: RNUM_W])
    );
  end

  assign elig_w = req_i & active_i & use_i & ~dpick_q & {NUM_REQ{~hazard_i}};

  logic [NUM_REQ-1:0] raw_gnt;
  prio_pick #(.N(NUM_REQ)) u_pick (
    .cand_i(elig_w),
    .gnt_o (raw_gnt),
    .any_o (any_w)
  );
  assign grant_w = raw_gnt & {NUM_REQ{any_w}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dpick_q <= '0;
    else        dpick_q <= grant_w;
  end

  always_comb begin
    port_addr_o = '0;
    for (int unsigned k = 0; k < NUM_REQ; k++) begin
      port_addr_o = port_addr_o |
                    (grant_w[k] ? rnum_eff_w[k*RNUM_W +: RNUM_W] : '0);
    end
  end
  assign port_ren_o = |grant_w;
  assign go_rd_o    = dpick_q;

  bcast_steer #(.N(NUM_REQ), .W(DATA_W)) u_steer (
    .sel_i  (dpick_q),
    .data_i (port_rdata_i),
    .lanes_o(bcast_data_o)
  );
endmodule

// File: rtl/regport_arbiter_chk.sv
module regport_arbiter_chk #(
  parameter int unsigned NUM_REQ = 4,
  parameter int unsigned DATA_W  = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_REQ-1:0]        req_i,
  input logic [NUM_REQ-1:0]        active_i,
  input logic [NUM_REQ-1:0]        use_i,
  input logic                      hazard_i,
  input logic                      port_ren_o,
  input logic [NUM_REQ-1:0]        go_rd_o,
  input logic [NUM_REQ*DATA_W-1:0] bcast_data_o,
  input logic [NUM_REQ-1:0]        grant_w
);
  // R1
  ren_needs_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_ren_o |-> ((req_i & active_i & use_i) != '0));
  // R2
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_w));
  // R3
  hazard_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hazard_i |-> !port_ren_o);
  // R5
  strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_ren_o |=> ($countones(go_rd_o) == 1));
  // R5
  no_stray_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_ren_o |=> (go_rd_o == '0));
  // R6
  no_regrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_rd_o & grant_w) == '0);
  // R7
  quiet_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_rd_o == '0) |-> (bcast_data_o == '0));
endmodule

bind regport_arbiter regport_arbiter_chk #(.NUM_REQ(NUM_REQ), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .active_i    (active_i),
  .use_i       (use_i),
  .hazard_i    (hazard_i),
  .port_ren_o  (port_ren_o),
  .go_rd_o     (go_rd_o),
  .bcast_data_o(bcast_data_o),
  .grant_w     (grant_w)
);

// File: tb/test_regport_arbiter.sv
`timescale 1ns/1ps
module test_regport_arbiter;
  localparam int N  = 4;
  localparam int RW = 5;
  localparam int DW = 32;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req_i = '0, active_i = '0, use_i = '0, issue_i = '0;
  logic [N*RW-1:0] rnum_i = '0;
  logic hazard_i = 1'b0;
  logic [DW-1:0] port_rdata_i = '0;
  logic [RW-1:0] port_addr_o;
  logic port_ren_o;
  logic [N-1:0] go_rd_o;
  logic [N*DW-1:0] bcast_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  regport_arbiter #(.NUM_REQ(N), .RNUM_W(RW), .DATA_W(DW)) i_regport_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .active_i(active_i), .use_i(use_i),
    .issue_i(issue_i), .rnum_i(rnum_i), .hazard_i(hazard_i),
    .port_rdata_i(port_rdata_i), .port_addr_o(port_addr_o),
    .port_ren_o(port_ren_o), .go_rd_o(go_rd_o), .bcast_data_o(bcast_data_o)
  );

  // {req, active, use, hazard, exp_ren, exp_winner}
  localparam logic [15:0] VEC [NV] = '{
    {4'b0001, 4'b1111, 4'b1111, 1'b0, 1'b1, 2'd0},
    {4'b1010, 4'b1111, 4'b1111, 1'b0, 1'b1, 2'd1},
    {4'b1100, 4'b1111, 4'b1111, 1'b0, 1'b1, 2'd2},
    {4'b1111, 4'b1111, 4'b1111, 1'b0, 1'b1, 2'd0},
    {4'b1111, 4'b1111, 4'b1111, 1'b1, 1'b0, 2'd0},
    {4'b1111, 4'b1110, 4'b1111, 1'b0, 1'b1, 2'd1},
    {4'b1111, 4'b1111, 4'b1100, 1'b0, 1'b1, 2'd2},
    {4'b0110, 4'b1001, 4'b1111, 1'b0, 1'b0, 2'd0},
    {4'b1000, 4'b1000, 4'b1000, 1'b0, 1'b1, 2'd3},
    {4'b0000, 4'b1111, 4'b1111, 1'b0, 1'b0, 2'd0}
  };

  function automatic logic [RW-1:0] lane_rn(input int k);
    return RW'(k * 7 + 3);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_lanes(input string tag, input logic [N-1:0] sel, input logic [DW-1:0] d);
    for (int k = 0; k < N; k++)
      check(tag, 64'(bcast_data_o[k*DW +: DW]), sel[k] ? 64'(d) : 64'd0);
  endtask

  task automatic fall; @(negedge clk); endtask

  task automatic do_reset;
    rst_n = 1'b0; fall(); fall(); rst_n = 1'b1; fall();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] win_oh;
    active_i = '1; use_i = '1;
    do_reset();
    // R9: reset state; held register number cleared
    check("R9 go_rd after reset", 64'(go_rd_o), 0);
    check("R9 ren after reset", 64'(port_ren_o), 0);
    check_lanes("R9 lanes after reset", '0, '0);
    req_i = 4'b0010;
    rnum_i[RW +: RW] = 5'd19;
    #1 check("R9 held rnum cleared", 64'(port_addr_o), 0);
    check("R1 ren with eligible", 64'(port_ren_o), 1);
    req_i = '0;
    fall(); fall();

    // table: R1 R2 R3 R4 R5 R7
    issue_i = '1;
    for (int k = 0; k < N; k++) rnum_i[k*RW +: RW] = lane_rn(k);
    for (int v = 0; v < NV; v++) begin
      req_i = VEC[v][15:12]; active_i = VEC[v][11:8]; use_i = VEC[v][7:4];
      hazard_i = VEC[v][3];
      #1;
      check($sformatf("R4 ren vec%0d", v), 64'(port_ren_o), 64'(VEC[v][2]));
      check($sformatf("R4 addr vec%0d", v), 64'(port_addr_o),
            VEC[v][2] ? 64'(lane_rn(int'(VEC[v][1:0]))) : 64'd0);
      win_oh = VEC[v][2] ? (N'(1) << VEC[v][1:0]) : '0;
      fall();
      req_i = '0; hazard_i = 1'b0; port_rdata_i = 32'hA500_0000 + v;
      #1;
      check($sformatf("R5 go_rd vec%0d", v), 64'(go_rd_o), 64'(win_oh));
      check_lanes($sformatf("R7 lanes vec%0d", v), win_oh, port_rdata_i);
      fall();
      check($sformatf("R5 strobe one cycle vec%0d", v), 64'(go_rd_o), 0);
      check_lanes($sformatf("R7 quiet vec%0d", v), '0, '0);
    end
    active_i = '1; use_i = '1;

    // R6: constant request granted every other cycle
    req_i = 4'b0001;
    #1 check("R6 first grant", 64'(port_ren_o), 1);
    fall();
    check("R6 masked while strobing", 64'(port_ren_o), 0);
    check("R6 strobe", 64'(go_rd_o), 1);
    fall();
    check("R6 regrant", 64'(port_ren_o), 1);
    // R6 with a lower-priority competitor: it takes the masked cycle
    req_i = 4'b0011;
    fall();
    check("R6 competitor gets masked slot", 64'(port_addr_o), 64'(lane_rn(1)));
    req_i = '0;
    fall(); fall();

    // R8: issue-cycle direct use, then held value
    issue_i = '0;
    issue_i[0] = 1'b1; rnum_i[0 +: RW] = 5'd13; req_i = 4'b0001;
    #1 check("R8 issue cycle direct", 64'(port_addr_o), 13);
    fall();
    req_i = '0; rnum_i[0 +: RW] = 5'd9;
    fall();
    issue_i[0] = 1'b0; rnum_i[0 +: RW] = 5'd20; req_i = 4'b0001;
    #1 check("R8 held value used", 64'(port_addr_o), 9);
    req_i = '0;
    fall(); fall();

    // R3: hazard blocks even a lone requester; release restores
    req_i = 4'b1000; hazard_i = 1'b1;
    #1 check("R3 hazard blocks", 64'(port_ren_o), 0);
    fall();
    check("R3 no strobe after hazard", 64'(go_rd_o), 0);
    hazard_i = 1'b0;
    #1 check("R3 released", 64'(port_ren_o), 1);
    fall();
    req_i = '0;

    // R9: reset mid-strobe clears delayed pick
    check("R9 strobe before reset", 64'(go_rd_o), 64'(4'b1000));
    rst_n = 1'b0;
    #1 check("R9 strobe cleared by reset", 64'(go_rd_o), 0);
    fall(); rst_n = 1'b1; fall();
    req_i = 4'b0001;
    #1 check("R9 held rnum cleared again", 64'(port_addr_o), 0);
    req_i = '0;
    fall();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule